// File: doc/BRIEF.md
# Synthesizer Divider Configuration Register

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback divide value M, a 2-bit output divide select N and a 3-bit test select T. The settings come from one of two places. The first is a set of parallel pins, normally used once at power-up. The second is a three-wire serial port, made of a serial clock, a data line and a load strobe, which can retune the synthesizer later.

Serial bits enter a 14-bit shift register. Two level-sensitive load controls move either the shift register or the parallel pins into the configuration registers. The parallel control has priority and also holds the test field at zero. All of the logic runs on one fast system clock. The serial inputs are resynchronised into that clock, and the rising edges of the serial clock are found by edge detection. The top bit of the shift register is brought out so it can be shown on a test pin.

Top module: `cfg_divreg`

## Requirements
- R1: While `rst` is high, `m_o`, `n_o`, `t_o` and `sr_msb_o` go to zero on the next clock edge.
- R2: Each rising edge of `ser_clk_i`, seen after the synchronizer, shifts the shift register by one place. The bit on `ser_dat_i` enters the least significant end. `sr_msb_o` shows the bit that entered 13 shifts earlier.
- R3: After 14 shifts, the first three bits shifted in form T, the next two form N and the last nine form M. Each field arrives most significant bit first, so the first bit is T[2] and the last bit is M[0].
- R4: While `par_ld_i` is high and the synchronized `ser_ld_i` is high, the outputs follow the shift register with one clock of delay.
- R5: While `par_ld_i` is high and the synchronized `ser_ld_i` is low, the outputs hold the value they had when the serial load fell. Further shifting leaves them unchanged.
- R6: While `par_ld_i` is low, `m_o` and `n_o` follow `par_m_i` and `par_n_i` with one clock of delay, whatever the serial inputs do.
- R7: When `par_ld_i` goes high (with the serial load low), `m_o` and `n_o` keep the pin values from the last low cycle. Later changes on the pins have no effect.
- R8: While `par_ld_i` is low, `t_o` is forced to 000. This holds even when the serial load is high. The parallel path has no way to set T.
- R9: While the synchronized `ser_clk_i` shows no rising edge, the shift register does not change. Toggling `ser_dat_i` alone shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data bit, asynchronous |
| ser_ld_i | input | 1 | Serial load; the path is open while this is high |
| par_ld_i | input | 1 | Parallel load; the path is open while this is low |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide select |
| m_o | output | 9 | Registered feedback divide value |
| n_o | output | 2 | Registered output divide select |
| t_o | output | 3 | Registered test select |
| sr_msb_o | output | 1 | Most significant bit of the shift register |

## Verification
The bench builds the block with the default synchronizer depth of two stages. The reference model reads that depth as a parameter and delays its own serial history by the same number of cycles. The default depth therefore puts the whole serial latency path within reach: three cycles from a pin change to a shift or a load.

The bench shifts two full 14-bit words. These words cover every field boundary of the serial order. The bench also runs the parallel path with the serial load held high, which exercises the priority rule and the clearing of T.

// File: rtl/cfg_divreg_pkg.sv
package cfg_divreg_pkg;

    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int SR_W = T_W + N_W + M_W;

    // Field order inside the shift register is behavioural: T occupies the
    // top bits because it is shifted in first.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic sld;
    } ser_t;

    function automatic cfg_t cfg_from_sr(input logic [SR_W-1:0] sr);
        cfg_t c;
        c.t = sr[SR_W-1 -: T_W];
        c.n = sr[M_W +: N_W];
        c.m = sr[M_W-1:0];
        return c;
    endfunction

    function automatic cfg_t cfg_from_pins(input logic [M_W-1:0] m,
                                           input logic [N_W-1:0] n);
        cfg_t c;
        c.t = '0;
        c.n = n;
        c.m = m;
        return c;
    endfunction

endpackage

// File: rtl/cfg_divreg_sync.sv
module cfg_divreg_sync
    import cfg_divreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ser_t d,
    output ser_t q
);
    ser_t stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_divreg_shift.sv
module cfg_divreg_shift
    import cfg_divreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ser_t            s,
    output logic [SR_W-1:0] sr,
    output logic            rise
);
    logic sclk_prev;

    assign rise = s.sclk & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            sr        <= '0;
        end else begin
            sclk_prev <= s.sclk;
            if (rise) sr <= {sr[SR_W-2:0], s.sdat};
        end
    end
endmodule

// File: rtl/cfg_divreg_latch.sv
module cfg_divreg_latch
    import cfg_divreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            par_ld,
    input  logic [M_W-1:0]  par_m,
    input  logic [N_W-1:0]  par_n,
    input  logic            ser_ld,
    input  logic [SR_W-1:0] sr,
    output cfg_t            cfg
);
    // Parallel path open while par_ld is low and has priority; the serial
    // path is open while ser_ld is high. Closing either one holds the value.
    always_ff @(posedge clk) begin
        if (rst)          cfg <= '0;
        else if (!par_ld) cfg <= cfg_from_pins(par_m, par_n);
        else if (ser_ld)  cfg <= cfg_from_sr(sr);
    end
endmodule

// File: rtl/cfg_divreg.sv
module cfg_divreg
    import cfg_divreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_ld_i,
    input  logic           par_ld_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    output logic [M_W-1:0] m_o,
    output logic [N_W-1:0] n_o,
    output logic [T_W-1:0] t_o,
    output logic           sr_msb_o
);
    ser_t            ser_raw;
    ser_t            ser_s;
    logic [SR_W-1:0] sr_q;
    logic            shift_rise;
    logic            ld_sync;
    cfg_t            cfg_q;

    assign ser_raw.sclk = ser_clk_i;
    assign ser_raw.sdat = ser_dat_i;
    assign ser_raw.sld  = ser_ld_i;
    assign ld_sync      = ser_s.sld;

    cfg_divreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ser_raw),
        .q   (ser_s)
    );

    cfg_divreg_shift u_shift (
        .clk  (clk),
        .rst  (rst),
        .s    (ser_s),
        .sr   (sr_q),
        .rise (shift_rise)
    );

    cfg_divreg_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .par_ld (par_ld_i),
        .par_m  (par_m_i),
        .par_n  (par_n_i),
        .ser_ld (ld_sync),
        .sr     (sr_q),
        .cfg    (cfg_q)
    );

    assign m_o      = cfg_q.m;
    assign n_o      = cfg_q.n;
    assign t_o      = cfg_q.t;
    assign sr_msb_o = sr_q[SR_W-1];
endmodule

// File: rtl/cfg_divreg_chk.sv
module cfg_divreg_chk
    import cfg_divreg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            par_ld_i,
    input logic [M_W-1:0]  par_m_i,
    input logic [N_W-1:0]  par_n_i,
    input logic [M_W-1:0]  m_o,
    input logic [N_W-1:0]  n_o,
    input logic [T_W-1:0]  t_o,
    input logic            sr_msb_o,
    input logic [SR_W-1:0] sr_q,
    input logic            shift_rise,
    input logic            ld_sync
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (m_o == '0 && n_o == '0 && t_o == '0 && !sr_msb_o));

    a_r8_test_forced_zero: assert property (@(posedge clk) disable iff (rst)
        !par_ld_i |=> (t_o == '0));

    a_r6_pins_follow: assert property (@(posedge clk) disable iff (rst)
        !par_ld_i |=> (m_o == $past(par_m_i) && n_o == $past(par_n_i)));

    a_r4_serial_transparent: assert property (@(posedge clk) disable iff (rst)
        (par_ld_i && ld_sync) |=> ({t_o, n_o, m_o} == $past(sr_q)));

    a_r5_serial_hold: assert property (@(posedge clk) disable iff (rst)
        (par_ld_i && !ld_sync) |=> ($stable(m_o) && $stable(n_o) && $stable(t_o)));

    a_r9_no_shift_without_edge: assert property (@(posedge clk) disable iff (rst)
        !shift_rise |=> $stable(sr_q));

    a_r2_shift_moves_up: assert property (@(posedge clk) disable iff (rst)
        shift_rise |=> (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));
endmodule

bind cfg_divreg cfg_divreg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .par_ld_i   (par_ld_i),
    .par_m_i    (par_m_i),
    .par_n_i    (par_n_i),
    .m_o        (m_o),
    .n_o        (n_o),
    .t_o        (t_o),
    .sr_msb_o   (sr_msb_o),
    .sr_q       (sr_q),
    .shift_rise (shift_rise),
    .ld_sync    (ld_sync)
);

// File: tb/cfg_divreg_bench.sv
module cfg_divreg_bench;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic       par_ld = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [8:0] m_o;
    logic [1:0] n_o;
    logic [2:0] t_o;
    logic       sr_msb_o;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_divreg #(.SYNC_STAGES(D)) u_cfg_divreg (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_ld_i(ser_ld),
        .par_ld_i(par_ld), .par_m_i(par_m), .par_n_i(par_n),
        .m_o(m_o), .n_o(n_o), .t_o(t_o), .sr_msb_o(sr_msb_o)
    );

    // Behavioural reference model: serial history queue, integer register.
    int exp_m = 0, exp_n = 0, exp_t = 0, exp_sr = 0;
    int hc[$], hd[$], hl[$];

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            exp_m = 0; exp_n = 0; exp_t = 0; exp_sr = 0;
            hc = {}; hd = {}; hl = {};
            for (int i = 0; i <= D; i++) begin
                hc.push_back(0); hd.push_back(0); hl.push_back(0);
            end
        end else begin
            int now_c, old_c, now_d, now_l;
            now_c = hc[hc.size()-D];
            old_c = hc[hc.size()-D-1];
            now_d = hd[hd.size()-D];
            now_l = hl[hl.size()-D];
            if (!par_ld) begin
                exp_m = par_m; exp_n = par_n; exp_t = 0;
            end else if (now_l != 0) begin
                exp_t = exp_sr / 2048;
                exp_n = (exp_sr / 512) % 4;
                exp_m = exp_sr % 512;
            end
            if (now_c != 0 && old_c == 0)
                exp_sr = (exp_sr * 2 + now_d) % 16384;
            hc.push_back(ser_clk); hd.push_back(ser_dat); hl.push_back(ser_ld);
            void'(hc.pop_front()); void'(hd.pop_front()); void'(hl.pop_front());
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(par_ld ? "R4 m" : "R6 m", int'(m_o), exp_m);
            check(par_ld ? "R4 n" : "R6 n", int'(n_o), exp_n);
            check(par_ld ? "R3 t" : "R8 t", int'(t_o), exp_t);
            check("R2 msb", int'(sr_msb_o), exp_sr / 8192);
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_dat = b;
        cyc(4); ser_clk = 1'b1;
        cyc(4); ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) send_bit(w[i]);
        cyc(6);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [13:0] w1, w2;
        w1 = {3'b101, 2'b01, 9'h1A5};
        w2 = {3'b011, 2'b10, 9'h0C8};
        cyc(4);
        check("R1 m", int'(m_o), 0);
        check("R1 t", int'(t_o), 0);
        @(negedge clk); rst = 1'b0;

        // R6/R8: parallel path open, serial load high must not win
        par_m = 9'd300; par_n = 2'd2; ser_ld = 1'b1;
        cyc(6);
        check("R6 m", int'(m_o), 300);
        check("R8 t", int'(t_o), 0);
        ser_ld = 1'b0; cyc(5);
        par_ld = 1'b1; cyc(1);
        par_m = 9'd17; par_n = 2'd1;
        cyc(4);
        check("R7 m", int'(m_o), 300);
        check("R7 n", int'(n_o), 2);

        // R9: data toggling without a serial clock edge
        for (int i = 0; i < 6; i++) begin ser_dat = ~ser_dat; cyc(2); end
        check("R9 msb", int'(sr_msb_o), 0);

        // R2/R3: shift first word, outputs hold until load
        send_word(w1);
        check("R2 msb", int'(sr_msb_o), 1);
        check("R5 m", int'(m_o), 300);
        ser_ld = 1'b1; cyc(6);
        check("R3 t", int'(t_o), 5);
        check("R3 n", int'(n_o), 1);
        check("R3 m", int'(m_o), 'h1A5);
        ser_ld = 1'b0; cyc(5);

        // R5: second word shifted with load closed
        send_word(w2);
        check("R5 m", int'(m_o), 'h1A5);
        check("R5 t", int'(t_o), 5);
        check("R2 msb", int'(sr_msb_o), 0);
        ser_ld = 1'b1; cyc(6);
        check("R4 m", int'(m_o), 'h0C8);
        check("R4 t", int'(t_o), 3);

        // R8: parallel low clears T while serial load is still high
        par_ld = 1'b0; par_m = 9'h155; par_n = 2'd3;
        cyc(3);
        check("R8 t", int'(t_o), 0);
        check("R6 m", int'(m_o), 'h155);
        ser_ld = 1'b0; cyc(5);
        par_ld = 1'b1; cyc(2);
        par_m = 9'd0; cyc(3);
        check("R7 m", int'(m_o), 'h155);
        check("R7 n", int'(n_o), 3);
        finish_run();
    end
endmodule